// File: doc/BRIEF.md
# Single-Precision Floating-Point Adder/Subtractor

This block adds or subtracts two 32-bit IEEE 754 single-precision numbers in one clock cycle. Each word holds a sign bit in bit 31, an 8-bit exponent with a bias of 127 in bits 30:23, and a 23-bit fraction in bits 22:0. The fraction carries an implied leading one unless the exponent field is zero. A two-bit command picks add, subtract or idle. The sum or difference is rounded to nearest with ties to even and written into a result register on the rising clock edge. A four-bit status register is written in the same cycle.

The datapath works in five steps. It unpacks both operands. It swaps them so that the larger magnitude comes first. It shifts the smaller one right while keeping guard, round and sticky bits. It adds or subtracts the two significands. It then normalises the sum and rounds it. Zeros, subnormals, infinities and NaNs are all handled.

There is no valid/ready handshake. The command itself marks a transfer: idle means no new sample, and the registers keep their contents. A downstream stage that cannot accept a value must keep issuing idle.

Top module: `fpadd_core`

## Requirements
- R1: With command 2'b01 (add), the result register takes the correctly rounded value of opa + opb one clock edge later. Word layout: sign in bit 31, biased exponent in bits 30:23, fraction in bits 22:0.
- R2: With command 2'b10 (subtract), the result register takes the correctly rounded value of opa - opb one clock edge later.
- R3: With command 2'b00 or 2'b11 (idle), the result and status registers keep their values, whatever the operands are.
- R4: Rounding is to nearest. On an exact tie, the value whose fraction LSB is 0 is chosen.
- R5: An exact zero from operands of opposite effective sign gives +0 (0x00000000). A sum of two zeros with the same sign keeps that sign.
- R6: Subnormal operands (exponent field 0, fraction not zero) take part at their true value. A sum that crosses into the normal range gets exponent field 1.
- R7: Infinity combined with an infinity of opposite effective sign gives 0x7FC00000 and sets the invalid flag. Otherwise an infinite operand gives an infinity with that operand's effective sign and no flags.
- R8: Any NaN operand gives 0x7FC00000 with all flags clear.
- R9: A rounded result whose exponent would reach 255 gives an infinity with the correct sign and sets both the overflow and inexact flags.
- R10: Status bits are bit 3 invalid, bit 2 overflow, bit 1 underflow, bit 0 inexact. Inexact is set when rounding discards nonzero bits. Underflow is set when the result is inexact and its exponent field is 0.
- R11: While rst_n is low, result and status read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; registers update on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_sel | input | 2 | Command: 2'b01 add, 2'b10 subtract, 2'b00 or 2'b11 idle |
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand (subtrahend on subtract) |
| result | output | 32 | Registered rounded result |
| flags | output | 4 | Registered status: invalid, overflow, underflow, inexact |

## Verification
The bench goes after several corner cases, each with a distinct failure symptom.

- Ties between two representable values: a design that rounded half-up, or that lost the sticky bit, would land one unit of least precision off.
- Large exponent gaps: a design that lost the sticky bit there would also be one unit off.
- Cancellation of equal magnitudes: a design that kept the larger operand's sign would return -0 where +0 is required.
- Subnormal sums that carry into the normal range: a design that clamped badly would give a wrong exponent field.
- Overflow at the largest finite value: a missed overflow would give a NaN-shaped word or drop the inexact flag.
- Infinity minus infinity and NaN inputs: a wrong priority among the special cases would give an infinity instead of the quiet NaN.
- Idle cycles with changing operands: any leak through the hold path would show up directly at the outputs.

// File: rtl/fpadd_pkg.sv
package fpadd_pkg;
  localparam int EXP_W  = 8;
  localparam int FRAC_W = 23;
  localparam int WORD_W = 1 + EXP_W + FRAC_W;
  localparam int SIG_W  = FRAC_W + 1;   // significand with hidden bit
  localparam int ADD_W  = SIG_W + 3;    // plus guard, round, sticky
  localparam int SUM_W  = ADD_W + 1;    // plus carry out
  localparam int XEXP_W = EXP_W + 2;    // exponent headroom in normalise/round
  localparam int EXP_MAX = (1 << EXP_W) - 1;

  localparam int FLG_NV = 3;
  localparam int FLG_OF = 2;
  localparam int FLG_UF = 1;
  localparam int FLG_NX = 0;

  localparam logic [1:0] OP_ADD = 2'b01;
  localparam logic [1:0] OP_SUB = 2'b10;

  localparam logic [WORD_W-1:0] QNAN_WORD =
    {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  typedef struct packed {
    logic             sign;
    logic [EXP_W-1:0] expo;   // effective exponent, 1 for subnormals
    logic [SIG_W-1:0] sig;
    logic             is_zero;
    logic             is_inf;
    logic             is_nan;
  } unp_t;
endpackage

// File: rtl/fpadd_unpack.sv
module fpadd_unpack
  import fpadd_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output unp_t              u
);
  logic [EXP_W-1:0]  exp_raw;
  logic [FRAC_W-1:0] frac;
  logic              exp_zero;
  logic              exp_full;

  assign exp_raw  = word[WORD_W-2:FRAC_W];
  assign frac     = word[FRAC_W-1:0];
  assign exp_zero = (exp_raw == '0);
  assign exp_full = (exp_raw == EXP_W'(EXP_MAX));

  always_comb begin
    u.sign    = word[WORD_W-1];
    u.expo    = exp_zero ? EXP_W'(1) : exp_raw;
    u.sig     = {~exp_zero, frac};
    u.is_zero = exp_zero && (frac == '0);
    u.is_inf  = exp_full && (frac == '0);
    u.is_nan  = exp_full && (frac != '0);
  end
endmodule

// File: rtl/fpadd_align.sv
module fpadd_align
  import fpadd_pkg::*;
(
  input  unp_t              a,
  input  unp_t              b,
  input  logic              sub,
  output logic              sign_big,
  output logic              eff_sub,
  output logic [EXP_W-1:0]  exp_big,
  output logic [ADD_W-1:0]  big_add,
  output logic [ADD_W-1:0]  small_add
);
  logic             b_sign_eff;
  logic             a_ge;
  unp_t             big_u;
  unp_t             small_u;
  logic [EXP_W-1:0] diff;
  logic [ADD_W-1:0] wide;
  logic [ADD_W-1:0] lost_mask;

  always_comb begin
    b_sign_eff = b.sign ^ sub;
    a_ge       = {a.expo, a.sig} >= {b.expo, b.sig};
    big_u      = a_ge ? a : b;
    small_u    = a_ge ? b : a;
    sign_big   = a_ge ? a.sign : b_sign_eff;
    eff_sub    = a.sign ^ b_sign_eff;
    exp_big    = big_u.expo;
    diff       = big_u.expo - small_u.expo;
    big_add    = {big_u.sig, 3'b000};
    wide       = {small_u.sig, 3'b000};
    lost_mask  = ~({ADD_W{1'b1}} << diff);
    if ({2'b00, diff} >= XEXP_W'(ADD_W))
      small_add = {{(ADD_W-1){1'b0}}, |small_u.sig};
    else
      small_add = (wide >> diff) | ADD_W'(|(wide & lost_mask));
  end
endmodule

// File: rtl/fpadd_normalize.sv
module fpadd_normalize
  import fpadd_pkg::*;
(
  input  logic [ADD_W-1:0]  big_add,
  input  logic [ADD_W-1:0]  small_add,
  input  logic              eff_sub,
  input  logic [EXP_W-1:0]  exp_big,
  output logic [ADD_W-1:0]  norm,
  output logic [XEXP_W-1:0] norm_exp,
  output logic              sum_zero
);
  logic [SUM_W-1:0]  sum;
  logic [XEXP_W-1:0] lz;
  logic [XEXP_W-1:0] lim;
  logic [XEXP_W-1:0] sh;

  function automatic logic [XEXP_W-1:0] lead_zeros(input logic [ADD_W-1:0] v);
    lead_zeros = XEXP_W'(ADD_W);
    for (int i = 0; i < ADD_W; i++)
      if (v[i]) lead_zeros = XEXP_W'(ADD_W - 1 - i);
  endfunction

  always_comb begin
    sum      = eff_sub ? ({1'b0, big_add} - {1'b0, small_add})
                       : ({1'b0, big_add} + {1'b0, small_add});
    sum_zero = (sum == '0);
    lz       = lead_zeros(sum[ADD_W-1:0]);
    lim      = {2'b00, exp_big} - XEXP_W'(1);
    sh       = (lz < lim) ? lz : lim;
    if (sum[SUM_W-1]) begin
      norm     = {sum[SUM_W-1:2], sum[1] | sum[0]};
      norm_exp = {2'b00, exp_big} + XEXP_W'(1);
    end else begin
      norm     = sum[ADD_W-1:0] << sh;
      norm_exp = {2'b00, exp_big} - sh;
    end
  end
endmodule

// File: rtl/fpadd_round.sv
module fpadd_round
  import fpadd_pkg::*;
(
  input  unp_t              a,
  input  unp_t              b,
  input  logic              sign_big,
  input  logic              eff_sub,
  input  logic [ADD_W-1:0]  norm,
  input  logic [XEXP_W-1:0] norm_exp,
  input  logic              sum_zero,
  output logic [WORD_W-1:0] res,
  output logic [3:0]        flg
);
  localparam int PK_W = XEXP_W + FRAC_W;

  logic              up;
  logic              nx;
  logic [XEXP_W-1:0] e_field;
  logic [PK_W-1:0]   packed_w;
  logic [XEXP_W-1:0] rnd_exp;
  logic              ovf;

  always_comb begin
    nx       = |norm[2:0];
    up       = norm[2] & (norm[1] | norm[0] | norm[3]);
    e_field  = norm[ADD_W-1] ? norm_exp : '0;
    packed_w = {e_field, norm[ADD_W-2:3]} + PK_W'(up);
    rnd_exp  = packed_w[FRAC_W +: XEXP_W];
    ovf      = rnd_exp >= XEXP_W'(EXP_MAX);
    flg      = '0;
    if (a.is_nan || b.is_nan) begin
      res = QNAN_WORD;
    end else if (a.is_inf && b.is_inf && eff_sub) begin
      res         = QNAN_WORD;
      flg[FLG_NV] = 1'b1;
    end else if (a.is_inf || b.is_inf) begin
      res = {sign_big, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    end else if (sum_zero) begin
      res = {~eff_sub & sign_big, {(WORD_W-1){1'b0}}};
    end else if (ovf) begin
      res         = {sign_big, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
      flg[FLG_OF] = 1'b1;
      flg[FLG_NX] = 1'b1;
    end else begin
      res         = {sign_big, packed_w[EXP_W+FRAC_W-1:0]};
      flg[FLG_NX] = nx;
      flg[FLG_UF] = nx && (rnd_exp == '0);
    end
  end
endmodule

// File: rtl/fpadd_core.sv
module fpadd_core
  import fpadd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  op_sel,
  input  logic [31:0] opa,
  input  logic [31:0] opb,
  output logic [31:0] result,
  output logic [3:0]  flags
);
  logic              sub;
  logic              act;
  logic [WORD_W-1:0] opw [2];
  unp_t              opu [2];
  logic              sign_big;
  logic              eff_sub;
  logic [EXP_W-1:0]  exp_big;
  logic [ADD_W-1:0]  big_add;
  logic [ADD_W-1:0]  small_add;
  logic [ADD_W-1:0]  norm;
  logic [XEXP_W-1:0] norm_exp;
  logic              sum_zero;
  logic [WORD_W-1:0] res_d;
  logic [3:0]        flg_d;

  assign sub    = (op_sel == OP_SUB);
  assign act    = (op_sel == OP_ADD) || (op_sel == OP_SUB);
  assign opw[0] = opa;
  assign opw[1] = opb;

  for (genvar k = 0; k < 2; k++) begin : g_unp
    fpadd_unpack u_unp (.word(opw[k]), .u(opu[k]));
  end

  fpadd_align u_align (
    .a(opu[0]), .b(opu[1]), .sub(sub),
    .sign_big(sign_big), .eff_sub(eff_sub), .exp_big(exp_big),
    .big_add(big_add), .small_add(small_add)
  );

  fpadd_normalize u_norm (
    .big_add(big_add), .small_add(small_add), .eff_sub(eff_sub),
    .exp_big(exp_big), .norm(norm), .norm_exp(norm_exp), .sum_zero(sum_zero)
  );

  fpadd_round u_round (
    .a(opu[0]), .b(opu[1]), .sign_big(sign_big), .eff_sub(eff_sub),
    .norm(norm), .norm_exp(norm_exp), .sum_zero(sum_zero),
    .res(res_d), .flg(flg_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result <= '0;
      flags  <= '0;
    end else if (act) begin
      result <= res_d;
      flags  <= flg_d;
    end
  end
endmodule

// File: rtl/fpadd_core_chk.sv
module fpadd_core_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  op_sel,
  input logic [31:0] opa,
  input logic [31:0] opb,
  input logic [31:0] result,
  input logic [3:0]  flags
);
  logic act;
  logic nan_in;
  assign act    = (op_sel == 2'b01) || (op_sel == 2'b10);
  assign nan_in = (opa[30:23] == 8'hFF && opa[22:0] != 0) ||
                  (opb[30:23] == 8'hFF && opb[22:0] != 0);

  a_r11_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (result == 32'h0 && flags == 4'h0));

  a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !act |=> ($stable(result) && $stable(flags)));

  a_r8_nan_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (act && nan_in) |=> (result == 32'h7FC00000 && flags == 4'h0));

  a_r7_invalid_nan: assert property (@(posedge clk) disable iff (!rst_n)
    flags[3] |-> result[30:0] == 31'h7FC00000);

  a_r9_overflow_inf: assert property (@(posedge clk) disable iff (!rst_n)
    flags[2] |-> (result[30:0] == 31'h7F800000 && flags[0]));

  a_r10_uf_inexact: assert property (@(posedge clk) disable iff (!rst_n)
    flags[1] |-> (flags[0] && result[30:23] == 8'h00));
endmodule

bind fpadd_core fpadd_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .opa(opa), .opb(opb),
  .result(result), .flags(flags)
);

// File: tb/fpadd_core_tb_top.sv
module fpadd_core_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MW = 300;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  op_sel = 2'b00;
  logic [31:0] opa = '0;
  logic [31:0] opb = '0;
  logic [31:0] result;
  logic [3:0]  flags;

  int checks = 0;
  int failures = 0;
  logic [31:0] exp_r = '0;
  logic [3:0]  exp_f = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fpadd_core dut_i (
    .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .opa(opa), .opb(opb),
    .result(result), .flags(flags)
  );

  function automatic logic [MW-1:0] mag(input logic [31:0] w);
    logic [MW-1:0] m;
    if (w[30:23] == 0) m = MW'(w[22:0]);
    else m = MW'({1'b1, w[22:0]}) << (w[30:23] - 1);
    return m;
  endfunction

  // Behavioural reference: exact sum in units of 2^-149, then round.
  task automatic model(input logic [1:0] op, input logic [31:0] a,
                       input logic [31:0] b, inout logic [31:0] r,
                       inout logic [3:0] f);
    logic sa, sb, sgn, nx, up;
    logic [MW-1:0] ma, mb, s, rem, half, mant;
    int p, sh, ef;
    bit a_nan, b_nan, a_inf, b_inf;
    if (op != 2'b01 && op != 2'b10) return;
    sa = a[31];
    sb = b[31] ^ (op == 2'b10);
    a_nan = a[30:23] == 8'hFF && a[22:0] != 0;
    b_nan = b[30:23] == 8'hFF && b[22:0] != 0;
    a_inf = a[30:23] == 8'hFF && a[22:0] == 0;
    b_inf = b[30:23] == 8'hFF && b[22:0] == 0;
    if (a_nan || b_nan) begin r = 32'h7FC00000; f = 4'h0; return; end
    if (a_inf && b_inf && sa != sb) begin r = 32'h7FC00000; f = 4'h8; return; end
    if (a_inf) begin r = {sa, 31'h7F800000}; f = 0; return; end
    if (b_inf) begin r = {sb, 31'h7F800000}; f = 0; return; end
    ma = mag(a);
    mb = mag(b);
    if (sa == sb) begin s = ma + mb; sgn = sa; end
    else if (ma >= mb) begin s = ma - mb; sgn = sa; end
    else begin s = mb - ma; sgn = sb; end
    if (s == 0) begin r = {(sa == sb) ? sa : 1'b0, 31'h0}; f = 0; return; end
    p = 0;
    for (int i = MW-1; i >= 0; i--) if (s[i]) begin p = i; break; end
    if (p <= 23) begin r = {sgn, s[30:0]}; f = 0; return; end
    sh   = p - 23;
    mant = s >> sh;
    rem  = s & ((MW'(1) << sh) - 1);
    half = MW'(1) << (sh - 1);
    nx   = rem != 0;
    up   = (rem > half) || (rem == half && mant[0]);
    mant = mant + MW'(up);
    ef   = sh + 1;
    if (mant[24]) begin mant = mant >> 1; ef = ef + 1; end
    if (ef >= 255) begin r = {sgn, 31'h7F800000}; f = 4'b0101; return; end
    r = {sgn, 8'(ef), mant[22:0]};
    f = {3'b000, nx};
  endtask

  task automatic compare(input string tag, input logic [31:0] er, input logic [3:0] ef);
    checks++;
    if (result !== er || flags !== ef) begin
      failures++;
      $display("FAIL %s: result=%h flags=%b expected result=%h flags=%b",
               tag, result, flags, er, ef);
    end
  endtask

  task automatic step(input logic [1:0] op, input logic [31:0] a,
                      input logic [31:0] b, input string tag);
    @(negedge clk);
    op_sel = op; opa = a; opb = b;
    model(op, a, b, exp_r, exp_f);
    @(posedge clk);
    #1;
    compare(tag, exp_r, exp_f);
  endtask

  task automatic known(input logic [1:0] op, input logic [31:0] a,
                       input logic [31:0] b, input logic [31:0] hr,
                       input logic [3:0] hf, input string tag);
    step(op, a, b, tag);
    compare({tag, " hand"}, hr, hf);
  endtask

  function automatic logic [31:0] pick_operand(input logic [31:0] other);
    logic [31:0] w;
    int cls;
    cls = $urandom_range(0, 9);
    w = $urandom;
    case (cls)
      0: w[30:23] = 8'h00;
      1: w = {w[31], 8'hFF, (w[0] ? 23'h0 : w[22:0] | 23'h1)};
      2: w[30:23] = 8'hFE;
      3, 4: w[30:23] = other[30:23] + 8'($urandom_range(0, 2)) - 8'd1;
      5: w = {other[31] ^ w[0], other[30:1], w[1]};
      6: w = {w[31], 31'h0};
      default: ;
    endcase
    return w;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    compare("R11 reset state", 32'h0, 4'h0);
    @(negedge clk);
    rst_n = 1'b1;

    known(2'b01, 32'h3F800000, 32'h3F800000, 32'h40000000, 4'h0, "R1 1+1");
    known(2'b10, 32'h40000000, 32'h40400000, 32'hBF800000, 4'h0, "R2 2-3");
    known(2'b00, 32'h12345678, 32'h9ABCDEF0, 32'hBF800000, 4'h0, "R3 idle 00");
    known(2'b11, 32'h7F800000, 32'h3F800000, 32'hBF800000, 4'h0, "R3 idle 11");
    known(2'b01, 32'h3F800000, 32'h33800000, 32'h3F800000, 4'h1, "R4 tie even down");
    known(2'b01, 32'h3F800001, 32'h33800000, 32'h3F800002, 4'h1, "R4 tie even up");
    known(2'b10, 32'h3F800000, 32'h3F800000, 32'h00000000, 4'h0, "R5 cancel +0");
    known(2'b01, 32'h80000000, 32'h80000000, 32'h80000000, 4'h0, "R5 -0 + -0");
    known(2'b01, 32'h00000001, 32'h00000001, 32'h00000002, 4'h0, "R6 subnormal sum");
    known(2'b01, 32'h007FFFFF, 32'h00000001, 32'h00800000, 4'h0, "R6 into normal");
    known(2'b10, 32'h7F800000, 32'h7F800000, 32'h7FC00000, 4'h8, "R7 inf-inf");
    known(2'b01, 32'hFF800000, 32'h3F800000, 32'hFF800000, 4'h0, "R7 -inf+1");
    known(2'b01, 32'h7FC12345, 32'h3F800000, 32'h7FC00000, 4'h0, "R8 nan in");
    known(2'b01, 32'h7F7FFFFF, 32'h7F7FFFFF, 32'h7F800000, 4'h5, "R9 overflow");
    known(2'b10, 32'hFF7FFFFF, 32'h7F7FFFFF, 32'hFF800000, 4'h5, "R9 neg overflow");
    known(2'b01, 32'h3F800000, 32'h0DA24260, 32'h3F800000, 4'h1, "R10 inexact far");

    for (int n = 0; n < 6000; n++) begin
      logic [31:0] a, b;
      logic [1:0] op;
      a  = pick_operand(32'h3F800000 ^ 32'($urandom_range(0, 32'h3FFFFFFF)));
      b  = pick_operand(a);
      op = 2'($urandom_range(0, 5) == 0 ? 0 : ($urandom_range(0, 1) ? 1 : 2));
      step(op, a, b, "R1 R2 R4 R10 random vs model");
    end

    @(negedge clk);
    op_sel = 2'b00;
    rst_n  = 1'b0;
    #1;
    compare("R11 async reset", 32'h0, 4'h0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule